// File: doc/BRIEF.md
# Serial-to-Parallel Word Demultiplexer with Loss-of-Signal Squelch

This block sits behind a clock and data recovery stage. It takes the recovered serial bit stream together with its bit-rate clock and packs consecutive bits into 16-bit parallel words. From the bit clock it derives two output clocks. The word clock runs at one sixteenth of the bit rate. The auxiliary clock runs at half the word rate and can act as a slower reference for a downstream transmitter. Word boundaries come from a free-running bit counter. The block performs no framing or alignment search.

An optics module reports loss of signal on a single pin, and its active level differs from one module to another. A second pin gives the sense the board expects. The block declares loss whenever the two pins differ. While loss is declared, every published word is forced to zero. The divided clocks keep running throughout, so downstream logic stays clocked. Both pins are asynchronous, so they pass through a two-stage synchronizer before use.

Top module: `sipo_squelch_demux`

## Requirements
- R1: After reset, the parallel output is all zeros and both the word clock and the auxiliary clock are low.
- R2: Each word holds 16 consecutive serial bits. The first bit received lands on output bit 0 and the sixteenth on bit 15.
- R3: The word clock has a period of 16 bit-clock cycles, high for 8 and low for 8. It falls at the bit-clock edge that completes a word, and its first fall comes 16 bit-clock edges after reset is released.
- R4: The auxiliary clock toggles only at falling edges of the word clock, giving a period of 32 bit-clock cycles.
- R5: The parallel output changes only at the bit-clock edge where the word clock falls. It holds its value for the rest of the word.
- R6: Loss of signal is declared when the loss input and the polarity input are at different levels. When both are 0, or both are 1, words pass through unchanged.
- R7: If loss of signal is declared at the rising edge of the word clock, the word published at the following falling edge is all zeros. All-zero words keep coming at the word rate until the pins match again, and both divided clocks keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Recovered serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_din | input | 1 | Recovered serial data, one bit per clock |
| los_in | input | 1 | Loss-of-signal indication from the optics, asynchronous |
| pol_in | input | 1 | Expected sense of los_in; a mismatch means loss, asynchronous |
| par_dout | output | 16 | Assembled parallel word |
| word_clk | output | 1 | Bit clock divided by 16 |
| aux_clk | output | 1 | Bit clock divided by 32 |

## Verification
A bit counter that slips or counts wrong moves the word boundary. The first published word then shows up rotated or shifted at the ports, and the word-clock period check fails at the very next falling edge. An auxiliary clock that loses its phase with the word clock toggles at the wrong edge, which is seen within one word. A squelch flag that is sampled late or held too long produces one word that is zeroed when it should not be, or one live word that escapes during loss. The word-by-word scoreboard catches either case at the boundary where that word is published.

// File: rtl/sqdmx_pkg.sv
package sqdmx_pkg;

  // Loss is flagged when the optics indication disagrees with the expected sense.
  function automatic logic loss_of(input logic los, input logic pol);
    return los ^ pol;
  endfunction

  // Published word: zero while squelched, otherwise the assembled bits.
  function automatic logic [63:0] squelch_word(input logic [63:0] w, input logic sq);
    return sq ? 64'd0 : w;
  endfunction

endpackage

// File: rtl/sqdmx_clkdiv.sv
module sqdmx_clkdiv #(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic word_clk_o,
  output logic aux_clk_o,
  output logic word_end_o,
  output logic word_rise_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int LAST  = WORD_W - 1;
  localparam int HALF  = WORD_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic             aux_q;

  assign word_end_o  = (cnt_q == CNT_W'(LAST));
  assign word_rise_o = (cnt_q == CNT_W'(HALF - 1));
  assign word_clk_o  = (cnt_q >= CNT_W'(HALF));
  assign aux_clk_o   = aux_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      aux_q <= 1'b0;
    end else begin
      cnt_q <= word_end_o ? '0 : cnt_q + 1'b1;
      if (word_end_o) aux_q <= ~aux_q;
    end
  end

  // R3
  word_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_end_o |=> !word_clk_o);

  // R4
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_end_o |=> $stable(aux_clk_o));

  // R4
  aux_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_end_o |=> (aux_clk_o != $past(aux_clk_o)));
endmodule

// File: rtl/sqdmx_sync.sv
module sqdmx_sync #(
  parameter int STAGES = 2,
  parameter int BITS   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] async_i,
  output logic [BITS-1:0] sync_o
);
  logic [BITS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sqdmx_assemble.sv
module sqdmx_assemble
  import sqdmx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              word_end_i,
  input  logic              word_rise_i,
  input  logic              loss_i,
  output logic [WORD_W-1:0] data_o,
  output logic              sq_held_o
);
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] next_word;
  logic [WORD_W-1:0] out_q;
  logic              sq_q;

  // New bits enter at the top, so the earliest bit ends at bit 0.
  assign next_word = {din, shift_q[WORD_W-1:1]};
  assign data_o    = out_q;
  assign sq_held_o = sq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      out_q   <= '0;
      sq_q    <= 1'b0;
    end else begin
      shift_q <= next_word;
      if (word_rise_i) sq_q <= loss_i;
      if (word_end_i)
        out_q <= WORD_W'(squelch_word(64'(next_word), sq_q));
    end
  end

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_end_i |=> $stable(data_o));

  // R7
  squelch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end_i && sq_held_o) |=> (data_o == '0));

  // R7
  squelch_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_rise_i |=> $stable(sq_held_o));
endmodule

// File: rtl/sipo_squelch_demux.sv
module sipo_squelch_demux
  import sqdmx_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              ser_din,
  input  logic              los_in,
  input  logic              pol_in,
  output logic [WORD_W-1:0] par_dout,
  output logic              word_clk,
  output logic              aux_clk
);
  logic       word_end;
  logic       word_rise;
  logic [1:0] pins_sync;
  logic       loss_now;
  logic       sq_held;

  sqdmx_clkdiv #(.WORD_W(WORD_W)) u_div (
    .clk        (clk_bit),
    .rst_n      (rst_n),
    .word_clk_o (word_clk),
    .aux_clk_o  (aux_clk),
    .word_end_o (word_end),
    .word_rise_o(word_rise)
  );

  sqdmx_sync #(.STAGES(SYNC_DEPTH), .BITS(2)) u_sync (
    .clk    (clk_bit),
    .rst_n  (rst_n),
    .async_i({los_in, pol_in}),
    .sync_o (pins_sync)
  );

  assign loss_now = loss_of(pins_sync[1], pins_sync[0]);

  sqdmx_assemble #(.WORD_W(WORD_W)) u_asm (
    .clk        (clk_bit),
    .rst_n      (rst_n),
    .din        (ser_din),
    .word_end_i (word_end),
    .word_rise_i(word_rise),
    .loss_i     (loss_now),
    .data_o     (par_dout),
    .sq_held_o  (sq_held)
  );

  // R7
  loss_capture_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    word_rise |=> (sq_held == loss_now || $past(loss_now) == sq_held));

  // R3
  rise_edge_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    word_rise |=> $rose(word_clk));
endmodule

// File: tb/sipo_squelch_demux_test.sv
module sipo_squelch_demux_test;
  logic        clk_bit = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_din = 1'b0;
  logic        los_in = 1'b0;
  logic        pol_in = 1'b0;
  logic [15:0] par_dout;
  logic        word_clk;
  logic        aux_clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  logic [15:0] exp_q[$];
  bit          sq_q[$];

  sipo_squelch_demux uut (
    .clk_bit (clk_bit),
    .rst_n   (rst_n),
    .ser_din (ser_din),
    .los_in  (los_in),
    .pol_in  (pol_in),
    .par_dout(par_dout),
    .word_clk(word_clk),
    .aux_clk (aux_clk)
  );

  always #5 clk_bit = ~clk_bit;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Driver: publishes the expected word, then shifts its bits in LSB first.
  task automatic send_word(input logic [15:0] w, input logic l, input logic p);
    bit sq;
    sq = (l != p);
    los_in = l;
    pol_in = p;
    exp_q.push_back(sq ? 16'h0000 : w);
    sq_q.push_back(sq);
    for (int i = 0; i < 16; i++) begin
      ser_din = w[i];
      @(posedge clk_bit);
      #2;
    end
  endtask

  // Monitor
  int          edge_cnt = 0;
  int          last_fall = 0;
  int          rise_at = 0;
  logic        wc_prev = 1'b0;
  logic [15:0] dout_prev = 16'h0;
  logic        exp_aux = 1'b0;

  always @(posedge clk_bit) if (rst_n) edge_cnt++;

  always @(negedge clk_bit) begin
    if (rst_n && started) begin
      if (word_clk && !wc_prev) rise_at = edge_cnt;
      if (!word_clk && wc_prev) begin
        check(edge_cnt - last_fall == 16, "R3 word period", edge_cnt - last_fall, 16);
        check(edge_cnt - rise_at == 8, "R3 word high time", edge_cnt - rise_at, 8);
        last_fall = edge_cnt;
        exp_aux = ~exp_aux;
        check(aux_clk == exp_aux, "R4 aux toggle", aux_clk, exp_aux);
        if (exp_q.size() > 0) begin
          logic [15:0] e;
          bit s;
          e = exp_q.pop_front();
          s = sq_q.pop_front();
          if (s) check(par_dout == e, "R7 squelched word", par_dout, e);
          else   check(par_dout == e, "R2 R6 assembled word", par_dout, e);
        end
      end else begin
        check(par_dout == dout_prev, "R5 data hold", par_dout, dout_prev);
        check(aux_clk == exp_aux, "R4 aux hold", aux_clk, exp_aux);
      end
    end
    wc_prev = word_clk;
    dout_prev = par_dout;
  end

  initial begin
    repeat (4) @(posedge clk_bit);
    #2;
    // R1 reset state
    check(par_dout == 16'h0, "R1 reset data", par_dout, 0);
    check(word_clk == 1'b0, "R1 reset word clock", word_clk, 0);
    check(aux_clk == 1'b0, "R1 reset aux clock", aux_clk, 0);
    rst_n = 1'b1;
    started = 1'b1;
    send_word(16'h0001, 1'b0, 1'b0);  // R2 first bit to bit 0
    send_word(16'h8000, 1'b0, 1'b0);  // R2 last bit to bit 15
    send_word(16'hA5C3, 1'b1, 1'b1);  // R6 both high passes
    send_word(16'hFFFF, 1'b1, 1'b0);  // R7 loss, mismatch one way
    send_word(16'h5A5A, 1'b1, 1'b0);  // R7 loss continues
    send_word(16'h1234, 1'b0, 1'b1);  // R7 mismatch other way
    send_word(16'hBEEF, 1'b0, 1'b0);  // R6 recovery
    send_word(16'h0F0F, 1'b1, 1'b1);
    send_word(16'hFFFF, 1'b0, 1'b0);
    send_word(16'h0000, 1'b0, 1'b0);
    repeat (20) @(posedge clk_bit);
    #2;
    check(exp_q.size() == 0, "R5 all words published", exp_q.size(), 0);
    finish_test();
  end

  initial begin
    repeat (20000) @(posedge clk_bit);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_test();
  end
endmodule